// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a memory-mapped watchdog with a 64-bit up-counter. Software sees the count and the timeout period as pairs of 32-bit registers. Before the watchdog is armed, software loads a period, selects the 64-bit watchdog timer mode, releases both counter halves and picks a run mode. It then arms the block by writing two fixed 16-bit keys, one after the other, into the key field of the control register. After that, software must keep servicing the watchdog with the same two-key pair before the count reaches the period.

Once armed, the block locks itself. Configuration writes are dropped and no register write can disarm it. A key that is not the expected next one counts as a fault. A timeout and a bad key both set a sticky flag and drive a reset-request output for a fixed number of cycles. Only the asynchronous reset returns the block to the disabled state.

Top module: `keyseq_wdog`

## Requirements
- R1: After reset, `rst_req` is 0 and the control, count-low and period-low registers all read as zero.
- R2: While disarmed, the count, period, timer-control and global-control registers are writable and read back. Timer control keeps only bits 7:6, the run mode. Global control keeps only bits 3:0: bits 3:2 are the timer mode, bit 0 releases the low counter half and bit 1 releases the high half.
- R3: The key field of the control register (offset 0x28) is bits 31:16, and bit 14 is the enable bit. While disarmed, only key 0xA5C6 written together with the enable bit arms the block (pre-active). Any other write leaves it disarmed and raises no reset request. A control read shows bit 14 = 1 whenever the block is armed.
- R4: In pre-active, key 0xDA7E moves the block to active. The counter then advances once per cycle from zero, but only when the timer mode is 2, both halves are released and the run mode is 1 or 2.
- R5: A timeout occurs on the counting cycle in which the count equals the 64-bit period. With period P, `rst_req` rises P+1 cycles after the activating write. A period of 0 times out on the first counting cycle.
- R6: While active, key 0xA5C6 followed by 0xDA7E clears the counter to zero on the cycle the second key is accepted. Counting then restarts from zero.
- R7: While armed, any key other than the expected next key raises the flag and `rst_req` on the next cycle. This applies in pre-active as well as in active.
- R8: While armed, writes to the count, period, timer-control and global-control registers have no effect.
- R9: The enable bit has no effect on writes once the block is armed. The armed indication cannot be cleared by any write.
- R10: `rst_req` is high for exactly 4 consecutive cycles per event. The flag (control bit 15) stays set until reset. After the flag is set, later faults raise no new pulse.
- R11: If a service sequence completes on the same cycle that the count equals the period, the timeout wins. The flag is set, a pulse is issued and the count stays at the period value.
- R12: When the timer mode is not 2, the counter does not advance while armed and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is valid after the next clock edge |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | Reset-request pulse |

## Verification
Two functions can fall in the same cycle: completing a service sequence, and the count reaching its period. The bench provokes this by arming with a period of 3, waiting two cycles, and then writing the two service keys so that the second key lands on the cycle the count equals 3. It judges the outcome at the ports. A reset-request pulse must appear, and a read of the count must return 3 rather than 0. A second overlap, a bad key arriving after the flag is already set, is judged by the absence of any new pulse.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic [1:0] {KS_OFF, KS_PRE, KS_RUN, KS_SVC} kstate_e;

    localparam logic [15:0] KEY_ARM = 16'hA5C6;
    localparam logic [15:0] KEY_RUN = 16'hDA7E;

    localparam int unsigned EN_BIT   = 14;
    localparam int unsigned FLAG_BIT = 15;
    localparam int unsigned KEY_LSB  = 16;

    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;
    localparam logic [7:0] OFS_PRD_LO = 8'h18;
    localparam logic [7:0] OFS_PRD_HI = 8'h1C;
    localparam logic [7:0] OFS_TCTL   = 8'h20;
    localparam logic [7:0] OFS_GCTL   = 8'h24;
    localparam logic [7:0] OFS_WCTL   = 8'h28;

    localparam logic [1:0] TMODE_WDOG = 2'd2;
endpackage

// File: rtl/kwd_keyfsm.sv
module kwd_keyfsm
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [15:0] key,
    input  logic        en_bit,
    output logic        armed,
    output logic        running,
    output logic        svc_done,
    output logic        bad_key
);
    typedef struct packed {
        kstate_e st;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        svc_done = 1'b0;
        bad_key  = 1'b0;
        if (key_wr) begin
            unique case (fsm_q.st)
                KS_OFF: if (en_bit && key == KEY_ARM) fsm_d.st = KS_PRE;
                KS_PRE: if (key == KEY_RUN) fsm_d.st = KS_RUN; else bad_key = 1'b1;
                KS_RUN: if (key == KEY_ARM) fsm_d.st = KS_SVC; else bad_key = 1'b1;
                KS_SVC: begin
                    if (key == KEY_RUN) begin
                        fsm_d.st = KS_RUN;
                        svc_done = 1'b1;
                    end else begin
                        bad_key = 1'b1;
                    end
                end
                default: fsm_d.st = KS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: KS_OFF};
        else        fsm_q <= fsm_d;
    end

    assign armed   = (fsm_q.st != KS_OFF);
    assign running = (fsm_q.st == KS_RUN) || (fsm_q.st == KS_SVC);
endmodule

// File: rtl/kwd_count64.sv
module kwd_count64 #(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic              wr_prd_lo,
    input  logic              wr_prd_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic              count_en,
    input  logic              restart,
    output logic [FULL_W-1:0] cnt,
    output logic [FULL_W-1:0] prd,
    output logic              hit
);
    typedef struct packed {
        logic [FULL_W-1:0] cnt;
        logic [FULL_W-1:0] prd;
    } cnt_s;

    cnt_s c_d, c_q;

    assign hit = count_en && (c_q.cnt == c_q.prd);

    always_comb begin
        c_d = c_q;
        if (hit) begin
            c_d.cnt = c_q.cnt;
        end else if (restart) begin
            c_d.cnt = '0;
        end else if (count_en) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end else begin
            if (wr_cnt_lo) c_d.cnt[HALF_W-1:0]      = wdata;
            if (wr_cnt_hi) c_d.cnt[FULL_W-1:HALF_W] = wdata;
        end
        if (wr_prd_lo) c_d.prd[HALF_W-1:0]      = wdata;
        if (wr_prd_hi) c_d.prd[FULL_W-1:HALF_W] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;
    assign prd = c_q.prd;
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int unsigned LEN = 4,
    localparam int unsigned CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (trig)              left_d = CW'(LEN);
        else if (left_q != '0) left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PULSE_LEN = 4,
    localparam int unsigned FULL_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    typedef struct packed {
        logic [1:0]        run_mode;
        logic [1:0]        tmr_mode;
        logic [1:0]        half_rel;
        logic              flag;
        logic [DATA_W-1:0] rdata;
    } top_s;

    top_s t_d, t_q;

    logic armed, running, svc_done, bad_key;
    logic hit, count_en, trig, cfg_open, flag;
    logic [FULL_W-1:0] cnt, prd;
    logic wr_cnt_lo, wr_cnt_hi, wr_prd_lo, wr_prd_hi, wr_tctl, wr_gctl, wr_wctl;

    assign cfg_open  = !armed;
    assign wr_cnt_lo = bus_wr && cfg_open && bus_addr == ADDR_W'(OFS_CNT_LO);
    assign wr_cnt_hi = bus_wr && cfg_open && bus_addr == ADDR_W'(OFS_CNT_HI);
    assign wr_prd_lo = bus_wr && cfg_open && bus_addr == ADDR_W'(OFS_PRD_LO);
    assign wr_prd_hi = bus_wr && cfg_open && bus_addr == ADDR_W'(OFS_PRD_HI);
    assign wr_tctl   = bus_wr && cfg_open && bus_addr == ADDR_W'(OFS_TCTL);
    assign wr_gctl   = bus_wr && cfg_open && bus_addr == ADDR_W'(OFS_GCTL);
    assign wr_wctl   = bus_wr && bus_addr == ADDR_W'(OFS_WCTL);

    kwd_keyfsm u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_wctl),
        .key      (bus_wdata[KEY_LSB +: 16]),
        .en_bit   (bus_wdata[EN_BIT]),
        .armed    (armed),
        .running  (running),
        .svc_done (svc_done),
        .bad_key  (bad_key)
    );

    assign count_en = running && !t_q.flag
                   && t_q.tmr_mode == TMODE_WDOG
                   && t_q.half_rel == 2'b11
                   && (t_q.run_mode == 2'd1 || t_q.run_mode == 2'd2);

    kwd_count64 #(.HALF_W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cnt_lo (wr_cnt_lo),
        .wr_cnt_hi (wr_cnt_hi),
        .wr_prd_lo (wr_prd_lo),
        .wr_prd_hi (wr_prd_hi),
        .wdata     (bus_wdata),
        .count_en  (count_en),
        .restart   (svc_done),
        .cnt       (cnt),
        .prd       (prd),
        .hit       (hit)
    );

    assign trig = (hit || bad_key) && !t_q.flag;

    kwd_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .pulse (rst_req)
    );

    always_comb begin
        t_d = t_q;
        if (wr_tctl) t_d.run_mode = bus_wdata[7:6];
        if (wr_gctl) begin
            t_d.tmr_mode = bus_wdata[3:2];
            t_d.half_rel = bus_wdata[1:0];
        end
        t_d.flag = t_q.flag || hit || bad_key;
        if (bus_rd) begin
            t_d.rdata = '0;
            case (bus_addr)
                ADDR_W'(OFS_CNT_LO): t_d.rdata = cnt[DATA_W-1:0];
                ADDR_W'(OFS_CNT_HI): t_d.rdata = cnt[FULL_W-1:DATA_W];
                ADDR_W'(OFS_PRD_LO): t_d.rdata = prd[DATA_W-1:0];
                ADDR_W'(OFS_PRD_HI): t_d.rdata = prd[FULL_W-1:DATA_W];
                ADDR_W'(OFS_TCTL):   t_d.rdata[7:6] = t_q.run_mode;
                ADDR_W'(OFS_GCTL):   t_d.rdata[3:0] = {t_q.tmr_mode, t_q.half_rel};
                ADDR_W'(OFS_WCTL): begin
                    t_d.rdata[FLAG_BIT] = t_q.flag;
                    t_d.rdata[EN_BIT]   = armed;
                end
                default: t_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata = t_q.rdata;
    assign flag      = t_q.flag;
endmodule

module kwd_chk #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned FULL_W    = 64,
    parameter int unsigned PULSE_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_req,
    input logic              flag,
    input logic              armed,
    input logic              hit,
    input logic              svc_done,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [FULL_W-1:0] cnt,
    input logic [FULL_W-1:0] prd
);
    logic [7:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_len <= '0;
        else if (rst_req) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);

    // R9
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R5
    timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R8
    prd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_wr && (bus_addr == ADDR_W'(8'h18) || bus_addr == ADDR_W'(8'h1C)))
        |=> $stable(prd));

    // R6
    svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && !hit) |=> (cnt == '0));

    // R10
    pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $rose(flag));

    // R10
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (run_len < 8'(PULSE_LEN)));

    // R10
    pulse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (run_len == 8'(PULSE_LEN)));
endmodule

bind keyseq_wdog kwd_chk #(
    .ADDR_W    (ADDR_W),
    .FULL_W    (FULL_W),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .flag     (flag),
    .armed    (armed),
    .hit      (hit),
    .svc_done (svc_done),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cnt      (cnt),
    .prd      (prd)
);

// File: tb/keyseq_wdog_test.sv
module keyseq_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] K_ARM_EN = 32'hA5C6_4000;
    localparam logic [31:0] K_RUN_EN = 32'hDA7E_4000;
    localparam logic [31:0] K_ARM    = 32'hA5C6_0000;
    localparam logic [31:0] K_RUN    = 32'hDA7E_0000;

    // {is_write, addr, data, expected read}
    localparam logic [72:0] VEC [11] = '{
        {1'b1, 8'h18, 32'h1234_5678, 32'h0},
        {1'b0, 8'h18, 32'h0,         32'h1234_5678},
        {1'b1, 8'h1C, 32'h0000_ABCD, 32'h0},
        {1'b0, 8'h1C, 32'h0,         32'h0000_ABCD},
        {1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h20, 32'h0,         32'h0000_00C0},
        {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h24, 32'h0,         32'h0000_000F},
        {1'b1, 8'h10, 32'h0000_0055, 32'h0},
        {1'b0, 8'h10, 32'h0,         32'h0000_0055},
        {1'b0, 8'h28, 32'h0,         32'h0}
    };

    keyseq_wdog uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic setup(input logic [31:0] period);
        wr(8'h18, period);
        wr(8'h1C, 32'h0);
        wr(8'h24, 32'h0000_000B);
        wr(8'h20, 32'h0000_0080);
    endtask

    task automatic arm();
        wr(8'h28, K_ARM_EN);
        wr(8'h28, K_RUN_EN);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int highs;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
        rd(8'h28, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h10, v); chk("R1 cnt_lo", v, 32'h0);
        rd(8'h18, v); chk("R1 prd_lo", v, 32'h0);

        // R2 table walk
        for (int i = 0; i < 11; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], v);
                chk("R2 table read", v, VEC[i][31:0]);
            end
        end

        // R3 disarmed key handling
        do_reset();
        wr(8'h28, K_RUN_EN);
        rd(8'h28, v); chk("R3 wrong key stays off", v, 32'h0);
        wr(8'h28, K_ARM);
        rd(8'h28, v); chk("R3 no enable stays off", v, 32'h0);
        chk("R3 no reset request", {31'b0, rst_req}, 32'h0);
        wr(8'h28, K_ARM_EN);
        rd(8'h28, v); chk("R3 armed bit", v, 32'h0000_4000);

        // R8 lock in pre-active
        wr(8'h18, 32'h7);
        rd(8'h18, v); chk("R8 period locked", v, 32'h0);
        wr(8'h24, 32'hB);
        rd(8'h24, v); chk("R8 gctl locked", v, 32'h0);

        // R9 enable clear ignored, R12 no counting in wrong mode
        wr(8'h28, K_RUN);
        rd(8'h28, v); chk("R9 still armed", v, 32'h0000_4000);
        repeat (5) @(negedge clk);
        rd(8'h10, v); chk("R12 counter idle", v, 32'h0);
        chk("R12 no timeout", {31'b0, rst_req}, 32'h0);

        // R5 timeout with period 5, R10 pulse length
        do_reset();
        setup(32'd5);
        arm();
        repeat (5) @(negedge clk);
        chk("R5 no early timeout", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        chk("R5 timeout at P+1", {31'b0, rst_req}, 32'h1);
        highs = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rst_req) highs++;
        end
        chk("R10 pulse length", highs, 32'd4);
        rd(8'h28, v); chk("R10 flag set", v, 32'h0000_C000);

        // R10 no second pulse
        wr(8'h28, 32'h0);
        highs = 0;
        for (int i = 0; i < 6; i++) begin
            if (rst_req) highs++;
            @(negedge clk);
        end
        chk("R10 no second pulse", highs, 32'd0);
        rd(8'h28, v); chk("R10 flag sticky", v, 32'h0000_C000);

        // R5 period zero
        do_reset();
        setup(32'd0);
        arm();
        chk("R5 zero period before count", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        chk("R5 zero period first cycle", {31'b0, rst_req}, 32'h1);

        // R4 counting, R6 service
        do_reset();
        setup(32'd100);
        arm();
        rd(8'h10, v); chk("R4 count starts at 0", v, 32'h0);
        rd(8'h10, v); chk("R4 count advances", v, 32'h1);
        repeat (7) @(negedge clk);
        wr(8'h28, K_ARM);
        wr(8'h28, K_RUN);
        rd(8'h10, v); chk("R6 cleared on service", v, 32'h0);
        rd(8'h10, v); chk("R6 count restarts", v, 32'h1);
        chk("R6 no reset request", {31'b0, rst_req}, 32'h0);

        // R7 illegal key while active
        do_reset();
        setup(32'd100);
        arm();
        wr(8'h28, 32'h0000_4000);
        chk("R7 active bad key", {31'b0, rst_req}, 32'h1);
        rd(8'h28, v); chk("R7 flag", v, 32'h0000_C000);

        // R7 illegal key in pre-active
        do_reset();
        wr(8'h28, K_ARM_EN);
        wr(8'h28, 32'h1234_4000);
        chk("R7 pre-active bad key", {31'b0, rst_req}, 32'h1);

        // R11 service completes on the timeout cycle
        do_reset();
        setup(32'd3);
        arm();
        repeat (2) @(negedge clk);
        wr(8'h28, K_ARM);
        wr(8'h28, K_RUN);
        chk("R11 timeout wins", {31'b0, rst_req}, 32'h1);
        rd(8'h10, v); chk("R11 count held", v, 32'd3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule